// File: doc/BRIEF.md
# Synchronous rectifier pulse generator

This block produces the controller-side synchronous rectifier command for one half-bridge leg of a resonant converter. It runs on a fast counter clock and watches the primary-side gate command. It rises a programmed dead time after each primary rising edge. It then drops at whichever of two points comes first, shifted by a signed trim. The first point tracks the primary falling edge minus the dead time. The second is a clamped pulse width measured from its own rising edge.

The primary falling edge is not known in advance. The tracking point is therefore predicted from the primary high time of the cycle that has just ended. The trim is an accumulator. At the start of every cycle it adds the correction step from the tuning block and then saturates to programmed limits. A second instance serves the other leg.

All times below are in clock ticks. A primary rise is "detected" at the first clock edge that samples the primary gate high after it was sampled low. The tick counter reads 0 right after that edge. The measured width W is the number of edges that sampled the primary high during the previous high phase.

Top module: `sr_pulse_gen`

## Requirements
- R1: While the synchronous active-low reset is sampled low, the trim accumulator is cleared to zero and the output `sr_in` is low from the next clock edge onward.
- R2: `sr_in` rises when the tick counter since the detected primary rise equals `dead_ticks`, i.e. `dead_ticks` edges after the detecting edge.
- R3: When W − `dead_ticks` is below `dead_ticks` + `clamp_ticks`, `sr_in` falls when the tick counter reaches W − `dead_ticks` + trim (tracking point).
- R4: When `dead_ticks` + `clamp_ticks` is not above W − `dead_ticks`, `sr_in` falls when the tick counter reaches `dead_ticks` + `clamp_ticks` + trim (clamp point).
- R5: At each detected primary rise, the trim becomes trim + `trim_step`, saturated to [`trim_min`, `trim_max`]. Both are signed two's complement, and the limits are expected to bracket zero. The new value applies to that same cycle.
- R6: The trim changes only at a detected primary rise. Changes of `trim_step` at other times have no effect on the pulse.
- R7: If the primary gate is sampled low while the tick counter is below `dead_ticks`, `sr_in` stays low for the rest of that cycle.
- R8: The measured width is zero after reset, so the first cycle after reset produces no pulse.
- R9: A new detected primary rise restarts the tick counter and ends any pulse in progress. With a non-zero dead time, `sr_in` is low on the next cycle. The pulse may otherwise extend past the primary falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pri_gate | input | 1 | Primary-side gate command |
| dead_ticks | input | CW | Dead time in ticks |
| clamp_ticks | input | CW | Clamped pulse width in ticks |
| trim_step | input | TW | Signed trim correction, taken at each cycle start |
| trim_min | input | TW | Signed lower trim limit |
| trim_max | input | TW | Signed upper trim limit |
| sr_in | output | 1 | Synchronous rectifier command |

## Verification
Several rules are checked on every cycle by assertions:
- the reset state;
- the rising edge landing exactly on the dead-time count;
- the trim staying inside its limits after each update and holding between cycle starts;
- the output staying low once the primary is low with no pulse;
- the output dropping on a restart.

Other behaviours only show up in the bench's scenarios, where a behavioural model predicts the output on every clock:
- which falling point wins, tracking or clamp;
- the exact falling tick with trim applied;
- trim saturation over several cycles;
- the absent first pulse;
- truncation of a pulse that outlives a short primary period.

// File: rtl/srpg_pkg.sv
package srpg_pkg;

  // Add a signed step to an accumulator and clip it into [lo, hi].
  function automatic int sat_add(int acc, int step, int lo, int hi);
    int s;
    s = acc + step;
    if (s > hi) s = hi;
    if (s < lo) s = lo;
    return s;
  endfunction

  // Falling point in ticks after the detected primary rise:
  // the earlier of the tracking point and the clamp point, then trimmed.
  function automatic int pick_end(int width, int dead, int clamp, int trim);
    int trk;
    int clp;
    trk = width - dead;
    clp = dead + clamp;
    return ((trk < clp) ? trk : clp) + trim;
  endfunction

endpackage

// File: rtl/srpg_edge_meas.sv
module srpg_edge_meas #(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pri_gate,
  output logic          rise_evt,
  output logic          fall_evt,
  output logic [CW-1:0] last_width
);
  localparam logic [CW-1:0] WMAX = {CW{1'b1}};

  logic          pri_q;
  logic [CW-1:0] hi_cnt;

  assign rise_evt   = pri_gate & ~pri_q;
  assign fall_evt   = ~pri_gate & pri_q;
  assign last_width = hi_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pri_q  <= 1'b0;
      hi_cnt <= '0;
    end else begin
      pri_q <= pri_gate;
      if (rise_evt)
        hi_cnt <= CW'(1);
      else if (pri_gate && hi_cnt != WMAX)
        hi_cnt <= hi_cnt + CW'(1);
    end
  end
endmodule

// File: rtl/srpg_trim_acc.sv
module srpg_trim_acc #(
  parameter int TW = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cycle_start,
  input  logic signed [TW-1:0] trim_step,
  input  logic signed [TW-1:0] trim_min,
  input  logic signed [TW-1:0] trim_max,
  output logic signed [TW-1:0] trim_q,
  output logic signed [TW-1:0] trim_next
);
  import srpg_pkg::*;

  assign trim_next = TW'(sat_add(int'(trim_q), int'(trim_step),
                                 int'(trim_min), int'(trim_max)));

  always_ff @(posedge clk) begin
    if (!rst_n)
      trim_q <= '0;
    else if (cycle_start)
      trim_q <= trim_next;
  end
endmodule

// File: rtl/srpg_pulse_timer.sv
module srpg_pulse_timer #(
  parameter int CW = 12,
  parameter int TW = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rise_evt,
  input  logic                 fall_evt,
  input  logic [CW-1:0]        last_width,
  input  logic [CW-1:0]        dead_ticks,
  input  logic [CW-1:0]        clamp_ticks,
  input  logic signed [TW-1:0] trim_next,
  output logic [CW-1:0]        cnt,
  output logic                 armed,
  output logic signed [CW+2:0] end_pt,
  output logic                 sr_in
);
  import srpg_pkg::*;

  localparam int            EW   = CW + 3;
  localparam logic [CW-1:0] CMAX = {CW{1'b1}};

  logic run;
  logic past_dead;
  logic before_end;

  assign past_dead  = (cnt >= dead_ticks);
  assign before_end = ($signed({{(EW-CW){1'b0}}, cnt}) < end_pt);
  assign sr_in      = run & armed & past_dead & before_end;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt    <= '0;
      run    <= 1'b0;
      armed  <= 1'b0;
      end_pt <= '0;
    end else if (rise_evt) begin
      cnt    <= '0;
      run    <= 1'b1;
      armed  <= 1'b1;
      end_pt <= EW'(pick_end(int'(last_width), int'(dead_ticks),
                             int'(clamp_ticks), int'(trim_next)));
    end else begin
      if (fall_evt && !past_dead)
        armed <= 1'b0;
      if (cnt != CMAX)
        cnt <= cnt + CW'(1);
    end
  end
endmodule

// File: rtl/sr_pulse_gen.sv
module sr_pulse_gen #(
  parameter int CW = 12,
  parameter int TW = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 pri_gate,
  input  logic [CW-1:0]        dead_ticks,
  input  logic [CW-1:0]        clamp_ticks,
  input  logic signed [TW-1:0] trim_step,
  input  logic signed [TW-1:0] trim_min,
  input  logic signed [TW-1:0] trim_max,
  output logic                 sr_in
);
  logic                 rise_evt;
  logic                 fall_evt;
  logic [CW-1:0]        last_width;
  logic signed [TW-1:0] trim_q;
  logic signed [TW-1:0] trim_next;
  logic [CW-1:0]        cnt;
  logic                 armed;
  logic signed [CW+2:0] end_pt;

  srpg_edge_meas #(.CW(CW)) i_meas (
    .clk        (clk),
    .rst_n      (rst_n),
    .pri_gate   (pri_gate),
    .rise_evt   (rise_evt),
    .fall_evt   (fall_evt),
    .last_width (last_width)
  );

  srpg_trim_acc #(.TW(TW)) i_trim (
    .clk         (clk),
    .rst_n       (rst_n),
    .cycle_start (rise_evt),
    .trim_step   (trim_step),
    .trim_min    (trim_min),
    .trim_max    (trim_max),
    .trim_q      (trim_q),
    .trim_next   (trim_next)
  );

  srpg_pulse_timer #(.CW(CW), .TW(TW)) i_timer (
    .clk         (clk),
    .rst_n       (rst_n),
    .rise_evt    (rise_evt),
    .fall_evt    (fall_evt),
    .last_width  (last_width),
    .dead_ticks  (dead_ticks),
    .clamp_ticks (clamp_ticks),
    .trim_next   (trim_next),
    .cnt         (cnt),
    .armed       (armed),
    .end_pt      (end_pt),
    .sr_in       (sr_in)
  );
endmodule

// File: rtl/srpg_checker.sv
module srpg_checker #(
  parameter int CW = 12,
  parameter int TW = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 pri_gate,
  input logic [CW-1:0]        dead_ticks,
  input logic signed [TW-1:0] trim_min,
  input logic signed [TW-1:0] trim_max,
  input logic                 rise_evt,
  input logic signed [TW-1:0] trim_q,
  input logic [CW-1:0]        cnt,
  input logic                 sr_in
);
  AST_RESET_LOW: assert property (@(posedge clk)
    !rst_n |=> (!sr_in && trim_q == '0)); // R1

  AST_RISE_AT_DEAD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sr_in) |-> (cnt == dead_ticks)); // R2

  AST_TRIM_IN_LIMITS: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_evt && trim_min <= trim_max) |=>
      (trim_q >= $past(trim_min) && trim_q <= $past(trim_max))); // R5

  AST_TRIM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rise_evt |=> $stable(trim_q)); // R6

  AST_NO_LATE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (!pri_gate && !sr_in) |=> !sr_in); // R7

  AST_RESTART_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_evt && dead_ticks != '0) |=> !sr_in); // R9
endmodule

bind sr_pulse_gen srpg_checker #(.CW(CW), .TW(TW)) i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .pri_gate   (pri_gate),
  .dead_ticks (dead_ticks),
  .trim_min   (trim_min),
  .trim_max   (trim_max),
  .rise_evt   (rise_evt),
  .trim_q     (trim_q),
  .cnt        (cnt),
  .sr_in      (sr_in)
);

// File: tb/test_sr_pulse_gen.sv
`timescale 1ns/1ps
module test_sr_pulse_gen;
  localparam int CW = 12;
  localparam int TW = 8;
  localparam int MAXC = (1 << CW) - 1;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic                 pri_gate = 1'b0;
  logic [CW-1:0]        dead_ticks = 12'd3;
  logic [CW-1:0]        clamp_ticks = 12'd20;
  logic signed [TW-1:0] trim_step = '0;
  logic signed [TW-1:0] trim_min = -8'sd4;
  logic signed [TW-1:0] trim_max = 8'sd5;
  logic                 sr_in;

  int    total = 0;
  int    bad = 0;
  bit    done = 0;
  string cur_req = "R1";
  int    hi_cycles = 0;

  always #5 clk = ~clk;

  sr_pulse_gen #(.CW(CW), .TW(TW)) i_sr_pulse_gen (
    .clk(clk), .rst_n(rst_n), .pri_gate(pri_gate),
    .dead_ticks(dead_ticks), .clamp_ticks(clamp_ticks),
    .trim_step(trim_step), .trim_min(trim_min), .trim_max(trim_max),
    .sr_in(sr_in)
  );

  // Behavioural reference: ticks since the cycle started, the width seen
  // last high phase, and a running trim.
  int m_since, m_width_now, m_width_done, m_trim, m_stop;
  bit m_started, m_allowed, m_prev_pri, m_exp;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_since = 0; m_width_now = 0; m_trim = 0; m_stop = 0;
      m_started = 0; m_allowed = 0; m_prev_pri = 0;
    end else begin
      if (pri_gate && !m_prev_pri) begin
        m_width_done = m_width_now;
        m_width_now  = 1;
        m_trim = m_trim + int'(trim_step);
        if (m_trim > int'(trim_max)) m_trim = int'(trim_max);
        if (m_trim < int'(trim_min)) m_trim = int'(trim_min);
        begin
          int a, b;
          a = m_width_done - int'(dead_ticks);
          b = int'(dead_ticks) + int'(clamp_ticks);
          m_stop = ((a < b) ? a : b) + m_trim;
        end
        m_since = 0; m_started = 1; m_allowed = 1;
      end else begin
        if (pri_gate && m_width_now < MAXC) m_width_now++;
        if (!pri_gate && m_prev_pri && m_since < int'(dead_ticks)) m_allowed = 0;
        if (m_since < MAXC) m_since++;
      end
      m_prev_pri = pri_gate;
    end
    m_exp = m_started && m_allowed && (m_since >= int'(dead_ticks)) && (m_since < m_stop);
  end

  always @(negedge clk) begin
    if (!done) begin
      total++;
      if (sr_in !== m_exp) begin
        bad++;
        $display("FAIL %s t=%0t sr_in=%0b expected=%0b", cur_req, $time, sr_in, m_exp);
      end
      if (sr_in === 1'b1) hi_cycles++;
    end
  end

  task automatic pri_cycle(input int hi, input int lo);
    for (int i = 0; i < hi; i++) begin @(negedge clk); pri_gate = 1'b1; end
    for (int i = 0; i < lo; i++) begin @(negedge clk); pri_gate = 1'b0; end
  endtask

  task automatic count_check(input string req, input bit want_some);
    total++;
    if ((hi_cycles > 0) != want_some) begin
      bad++;
      $display("FAIL %s pulse ticks=%0d expected %s", req, hi_cycles,
               want_some ? "nonzero" : "zero");
    end
    hi_cycles = 0;
  endtask

  initial begin
    cur_req = "R1";
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    hi_cycles = 0;
    cur_req = "R8";
    pri_cycle(30, 30);
    count_check("R8", 1'b0);
    cur_req = "R3";
    for (int k = 0; k < 6; k++) pri_cycle(15, 15);
    count_check("R3", 1'b1);
    cur_req = "R4";
    for (int k = 0; k < 4; k++) pri_cycle(40, 40);
    count_check("R4", 1'b1);
    cur_req = "R5";
    trim_step = 8'sd2;
    for (int k = 0; k < 5; k++) pri_cycle(40, 20);
    trim_step = -8'sd3;
    for (int k = 0; k < 5; k++) pri_cycle(15, 15);
    count_check("R5", 1'b1);
    cur_req = "R6";
    trim_step = 8'sd0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); pri_gate = 1'b1;
      repeat (4) @(negedge clk);
      trim_step = 8'sd4;
      repeat (14) @(negedge clk);
      pri_gate = 1'b0;
      repeat (3) @(negedge clk);
      trim_step = 8'sd0;
      repeat (16) @(negedge clk);
    end
    count_check("R6", 1'b1);
    cur_req = "R7";
    for (int k = 0; k < 5; k++) pri_cycle(2, 25);
    count_check("R7", 1'b0);
    cur_req = "R2";
    dead_ticks = 12'd0;
    for (int k = 0; k < 3; k++) pri_cycle(12, 12);
    dead_ticks = 12'd5;
    for (int k = 0; k < 3; k++) pri_cycle(20, 20);
    count_check("R2", 1'b1);
    cur_req = "R9";
    dead_ticks = 12'd3;
    trim_step = 8'sd5;
    for (int k = 0; k < 6; k++) pri_cycle(10, 1);
    trim_step = 8'sd0;
    pri_cycle(10, 20);
    count_check("R9", 1'b1);
    cur_req = "R1";
    pri_gate = 1'b1;
    repeat (8) @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    count_check("R1", 1'b1);
    repeat (3) @(negedge clk);
    count_check("R1", 1'b0);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1;
      bad++;
      total++;
      $display("FAIL watchdog %s expired", cur_req);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule